// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Port

This block is the digital back end of a two-channel sampling converter. A falling edge on the start-conversion strobe launches a conversion of both channels together. A busy flag stays high for a fixed number of system clocks while the conversion runs. When busy drops, the two results are taken from the `res_a` and `res_b` input ports, which stand in for the analog converter.

Each result leaves on its own serial data pin, most significant bit first. An active-low chip select frames the transfer, and each falling edge of the serial clock moves the data on by one bit. The falling edge of chip select enables the pins and presents the MSB. If chip select stays low for a second word length of clock falls, each pin goes on to carry the other channel's word. This lets a host read both results from a single pin.

High impedance is modelled with one output-enable signal per data pin. All strobes are sampled on the system clock, and edges are detected against the previous sample.

Top module: `twin_sample_serializer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, with chip select high, busy, both output enables and both data outputs are 0.
- R2: A sampled 1-to-0 transition of `start_n` while busy is low raises busy on the next edge. Busy then stays high for exactly CONV_CLKS cycles. A new start fall while busy is high is ignored and does not stretch busy.
- R3: The results are captured from `res_a`/`res_b` on the clock edge at which busy falls. Later changes on those ports do not alter the words that are shifted out.
- R4: One edge after chip select is sampled falling, both output enables are 1. Each data pin then shows bit DATA_W-1 of its own channel's most recent result.
- R5: Each later sampled falling edge of `sclk` inside the frame advances both pins by one bit, MSB first. After k falls, pin A shows bit DATA_W-1-k of result A and pin B shows bit DATA_W-1-k of result B. DATA_W is 12 or 14. A full word needs DATA_W-1 falls after the MSB. The data outputs change only on a chip-select fall, an `sclk` fall or a busy fall.
- R6: An `sclk` fall sampled in the same cycle as the chip-select fall is not counted. The MSB stays on the pins until the next `sclk` fall.
- R7: For fall counts k from DATA_W to 2*DATA_W-1, pin A shows bit 2*DATA_W-1-k of result B, and pin B shows the same bit of result A.
- R8: After 2*DATA_W counted falls, both data pins output 0 until chip select rises.
- R9: One edge after chip select is sampled high, both output enables are 0.
- R10: If chip select is low before busy falls, the pins are already enabled. On the edge at which busy falls, they show the MSBs of the new results. The next `sclk` fall shows the next bit.
- R11: If chip select is held low through reset, the output enables are 1 on the first edge after reset and stay 1. The MSB of each new result appears when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Start-conversion strobe, active on its falling edge |
| res_a | input | DATA_W | Channel A conversion result |
| res_b | input | DATA_W | Channel B conversion result |
| cs_n | input | 1 | Active-low chip select framing a read |
| sclk | input | 1 | Serial clock, data advances on its falling edge |
| busy | output | 1 | High while a conversion runs |
| dout_a | output | 1 | Serial data pin A |
| dout_b | output | 1 | Serial data pin B |
| oe_a | output | 1 | Output enable for pin A (0 = high impedance) |
| oe_b | output | 1 | Output enable for pin B (0 = high impedance) |

## Verification
A table of result pairs drives the main read path. The pairs are an alternating pattern, its complement, all-ones against all-zeros, and single set bits at the two ends. A wrong bit order, a lane swap or a missing zero tail therefore shows up as a mismatch on a specific fall count. Each pair is read through a full double-length frame. The result ports are changed as soon as busy falls, which separates a capture at busy fall from a design that follows its inputs. Directed runs use words whose MSB and next bit differ. This exposes whether a coincident clock fall was counted, and whether the early-select and tied-low reads reload at busy fall.

// File: rtl/tss_pkg.sv
package tss_pkg;

    // Command given to each output lane in a cycle
    typedef enum logic [1:0] {
        LANE_HOLD  = 2'd0,
        LANE_LOAD  = 2'd1,
        LANE_SHIFT = 2'd2
    } lane_cmd_t;

    // Fall detection between the previous and the current sample
    function automatic logic is_fall(input logic prev, input logic now);
        return prev & ~now;
    endfunction

    // Pick the lane command from the frame events of one cycle
    function automatic lane_cmd_t pick_cmd(input logic frame_open,
                                           input logic frame_fall,
                                           input logic conv_done,
                                           input logic clk_fall);
        if (frame_fall || (conv_done && frame_open))
            return LANE_LOAD;
        else if (frame_open && clk_fall)
            return LANE_SHIFT;
        else
            return LANE_HOLD;
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    import tss_pkg::*;

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= din;
    end

    assign fall = is_fall(prev_q, din);
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int CONV_CLKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_fall,
    output logic busy,
    output logic done
);
    localparam int CW = (CONV_CLKS > 1) ? $clog2(CONV_CLKS) : 1;

    logic [CW-1:0] remain_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
        end else if (!busy_q) begin
            if (start_fall) begin
                busy_q   <= 1'b1;
                remain_q <= CW'(CONV_CLKS - 1);
            end
        end else if (remain_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (remain_q == '0);
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  tss_pkg::lane_cmd_t cmd,
    input  logic [DATA_W-1:0] first_word,
    input  logic [DATA_W-1:0] second_word,
    output logic              dout
);
    import tss_pkg::*;

    localparam int SR_W = 2 * DATA_W;

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            unique case (cmd)
                LANE_LOAD:  sr_q <= {first_word, second_word};
                LANE_SHIFT: sr_q <= {sr_q[SR_W-2:0], 1'b0};
                default:    sr_q <= sr_q;
            endcase
        end
    end

    assign dout = sr_q[SR_W-1];
endmodule

// File: rtl/twin_sample_serializer.sv
module twin_sample_serializer #(
    parameter int DATA_W    = 12,
    parameter int CONV_CLKS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_n,
    input  logic [DATA_W-1:0] res_a,
    input  logic [DATA_W-1:0] res_b,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              busy,
    output logic              dout_a,
    output logic              dout_b,
    output logic              oe_a,
    output logic              oe_b
);
    import tss_pkg::*;

    localparam int LANES = 2;

    logic start_fall, cs_fall, sclk_fall;
    logic conv_done;
    logic frame_q;
    logic [DATA_W-1:0] cap_a_q, cap_b_q;
    logic [DATA_W-1:0] src_a, src_b;
    logic [LANES-1:0]  dout_vec;
    lane_cmd_t         cmd;

    sync_edge #(.RST_VAL(1'b1)) u_start_edge (
        .clk(clk), .rst(rst), .din(start_n), .fall(start_fall));
    sync_edge #(.RST_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst(rst), .din(cs_n), .fall(cs_fall));
    sync_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst(rst), .din(sclk), .fall(sclk_fall));

    conv_timer #(.CONV_CLKS(CONV_CLKS)) u_timer (
        .clk(clk), .rst(rst), .start_fall(start_fall),
        .busy(busy), .done(conv_done));

    // Result capture at the end of conversion
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a_q <= '0;
            cap_b_q <= '0;
        end else if (conv_done) begin
            cap_a_q <= res_a;
            cap_b_q <= res_b;
        end
    end

    // Words loaded into the lanes: fresh results in the completion cycle
    assign src_a = conv_done ? res_a : cap_a_q;
    assign src_b = conv_done ? res_b : cap_b_q;

    // Frame state: opened by the select fall, closed while select is high
    always_ff @(posedge clk) begin
        if (rst)                   frame_q <= 1'b0;
        else if (cs_fall)          frame_q <= 1'b1;
        else if (frame_q && cs_n)  frame_q <= 1'b0;
    end

    always_comb cmd = pick_cmd(frame_q, cs_fall, conv_done, sclk_fall);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_shifter #(.DATA_W(DATA_W)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .cmd         (cmd),
            .first_word  ((g == 0) ? src_a : src_b),
            .second_word ((g == 0) ? src_b : src_a),
            .dout        (dout_vec[g])
        );
    end

    assign dout_a = dout_vec[0];
    assign dout_b = dout_vec[1];
    assign oe_a   = frame_q;
    assign oe_b   = frame_q;
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
    parameter int CONV_CLKS = 20
) (
    input logic clk,
    input logic rst,
    input logic start_n,
    input logic cs_n,
    input logic sclk,
    input logic busy,
    input logic dout_a,
    input logic dout_b,
    input logic oe_a,
    input logic oe_b
);
    logic prev_start, prev_cs, prev_sclk, prev_busy;
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_start <= 1'b1;
            prev_cs    <= 1'b1;
            prev_sclk  <= 1'b0;
            prev_busy  <= 1'b0;
            run_len    <= 0;
        end else begin
            prev_start <= start_n;
            prev_cs    <= cs_n;
            prev_sclk  <= sclk;
            prev_busy  <= busy;
            run_len    <= busy ? run_len + 1 : 0;
        end
    end

    p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_start && !start_n && !busy) |=> busy);

    p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
        (prev_busy && !busy) |-> (run_len == CONV_CLKS));

    p_oe_on_r4: assert property (@(posedge clk) disable iff (rst)
        (prev_cs && !cs_n) |=> (oe_a && oe_b));

    p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!prev_cs && cs_n) |=> (!oe_a && !oe_b));

    p_dout_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!(prev_cs && !cs_n) && !(prev_sclk && !sclk))
            |=> (($stable(dout_a) && $stable(dout_b)) || $fell(busy)));
endmodule

bind twin_sample_serializer tss_checker #(.CONV_CLKS(CONV_CLKS)) u_tss_chk (
    .clk(clk), .rst(rst), .start_n(start_n), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .dout_a(dout_a), .dout_b(dout_b), .oe_a(oe_a), .oe_b(oe_b));

// File: tb/test_twin_sample_serializer.sv
module test_twin_sample_serializer;
    localparam int W    = 12;
    localparam int CONV = 20;
    localparam int NVEC = 5;

    // result pairs {a, b}
    localparam logic [2*W-1:0] VECS [NVEC] = '{
        {12'hA5C, 12'h3F1},
        {12'h5A3, 12'hC0E},
        {12'hFFF, 12'h000},
        {12'h800, 12'h001},
        {12'h555, 12'hAAA}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic [W-1:0] res_a = '0, res_b = '0;
    logic busy, dout_a, dout_b, oe_a, oe_b;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    twin_sample_serializer #(.DATA_W(W), .CONV_CLKS(CONV)) i_twin_sample_serializer (
        .clk(clk), .rst(rst), .start_n(start_n), .res_a(res_a), .res_b(res_b),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .dout_a(dout_a), .dout_b(dout_b),
        .oe_a(oe_a), .oe_b(oe_b));

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic sclk_pulse();
        sclk = 1'b1; step();
        sclk = 1'b0; step();
    endtask

    task automatic convert(input logic [W-1:0] a, input logic [W-1:0] b);
        res_a = a; res_b = b;
        start_n = 1'b0; step();
        start_n = 1'b1;
        repeat (CONV) step();
    endtask

    initial begin
        repeat (3) step();
        chk("R1 busy in reset", busy, 0);
        chk("R1 oe in reset", {oe_a, oe_b}, 0);
        chk("R1 dout in reset", {dout_a, dout_b}, 0);
        rst = 1'b0; step();
        chk("R1 after reset", {busy, oe_a, oe_b, dout_a, dout_b}, 0);

        // R2: busy length, start fall during busy ignored
        begin
            int n = 0;
            res_a = 12'h123; res_b = 12'h456;
            start_n = 1'b0; step();
            chk("R2 busy rises", busy, 1);
            while (busy && n < 100) begin
                n++;
                if (n == 2) start_n = 1'b1;
                if (n == 3) start_n = 1'b0;
                step();
            end
            chk("R2 busy length", n, CONV);
            start_n = 1'b1; step();
            chk("R2 no restart", busy, 0);
        end

        // table walk: R3, R4, R5, R7, R8, R9
        for (int v = 0; v < NVEC; v++) begin
            logic [2*W-1:0] pa, pb;
            pa = VECS[v];
            pb = {VECS[v][W-1:0], VECS[v][2*W-1:W]};
            convert(pa[2*W-1:W], pa[W-1:0]);
            res_a = ~res_a; res_b = ~res_b;   // R3: later port changes ignored
            step();
            cs_n = 1'b0; step();
            chk("R4 oe", {oe_a, oe_b}, 2'b11);
            chk("R4 msb a", dout_a, pa[2*W-1]);
            chk("R4 msb b", dout_b, pb[2*W-1]);
            for (int i = 1; i < 2*W; i++) begin
                sclk_pulse();
                if (i < W) begin
                    chk("R5 R3 bit a", dout_a, pa[2*W-1-i]);
                    chk("R5 R3 bit b", dout_b, pb[2*W-1-i]);
                end else begin
                    chk("R7 seq a", dout_a, pa[2*W-1-i]);
                    chk("R7 seq b", dout_b, pb[2*W-1-i]);
                end
            end
            for (int j = 0; j < 3; j++) begin
                sclk_pulse();
                chk("R8 zero tail", {dout_a, dout_b}, 0);
            end
            chk("R8 still enabled", {oe_a, oe_b}, 2'b11);
            cs_n = 1'b1; step();
            chk("R9 oe off", {oe_a, oe_b}, 0);
        end

        // R6: coincident clock fall not counted
        convert(12'hA5C, 12'h3F1);
        sclk = 1'b1; step();
        cs_n = 1'b0; sclk = 1'b0; step();
        chk("R6 msb kept a", dout_a, 1);
        chk("R6 msb kept b", dout_b, 0);
        sclk_pulse();
        chk("R6 next bit a", dout_a, 0);
        chk("R6 next bit b", dout_b, 0);
        sclk_pulse();
        chk("R6 third bit a", dout_a, 1);
        cs_n = 1'b1; step();

        // R10: select low before busy falls
        convert(12'h000, 12'hFFF);
        res_a = 12'h800; res_b = 12'h7FF;
        start_n = 1'b0; step();
        start_n = 1'b1; cs_n = 1'b0; step();
        chk("R10 early oe", {oe_a, oe_b}, 2'b11);
        chk("R10 old msb a", dout_a, 0);
        while (busy) step();
        chk("R10 new msb a", dout_a, 1);
        chk("R10 new msb b", dout_b, 0);
        sclk_pulse();
        chk("R10 next bit a", dout_a, 0);
        chk("R10 next bit b", dout_b, 1);
        cs_n = 1'b1; step();

        // R11: select tied low through reset
        rst = 1'b1; cs_n = 1'b0; step(); step();
        rst = 1'b0; step();
        chk("R11 oe after reset", {oe_a, oe_b}, 2'b11);
        convert(12'hA00, 12'h400);
        chk("R11 msb a at busy fall", dout_a, 1);
        chk("R11 msb b at busy fall", dout_b, 0);
        sclk_pulse();
        chk("R11 bit a", dout_a, 0);
        chk("R11 bit b", dout_b, 1);
        sclk_pulse();
        chk("R11 bit2 a", dout_a, 1);
        chk("R11 oe held", {oe_a, oe_b}, 2'b11);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule